// File: doc/BRIEF.md
# Page Program Buffer

This block gathers the data bytes of a serial page-program command in a 128-byte page latch, then commits the whole page to a behavioural byte array in one self-timed cycle. A load begins with a start address. Each strobed data byte lands at the current offset within that page. The offset advances only in its low seven bits, so a long load folds back onto the start of the same page instead of spilling into the next one. The serial front end, opcode decoder and protection logic sit outside this block. The front end tells the block whether an incomplete byte is pending at the moment it asks for a commit.

An accepted commit starts a timed cycle of a fixed number of clock ticks. During that cycle all 128 locations of the page are rewritten in ascending order: loaded bytes take their new value and every other byte is written back with its current contents. No prior erase is needed. A page erase request uses the same cycle to set a page to all ones. While the cycle runs, the busy flag is high and every request is ignored. The array's contents can be read at any time through a separate read port.

Top module: `page_program_buffer`

## Requirements
- R1: While reset is held and right after it, `busy` and `arrWe` are low.
- R2: A location is a 16-bit address. Bits 15..7 select the page and bits 6..0 the byte within it. The array keeps 2^PAGE_SEL_BITS pages, indexed by the low PAGE_SEL_BITS bits of the page number (default 16 pages, so address 0x0900 lands on the same storage as 0x0100). During a cycle, `arrAddr[15:7]` stays equal to the captured page.
- R3: A load starts at offset `startAddr[6:0]` and advances by one per byte, modulo 128. A byte sent past offset 127 goes to offset 0 of the same page, and a later byte at an offset overwrites an earlier one.
- R4: After a commit, each loaded offset of the page holds its last loaded byte. Every other byte of that page, and every other page, is unchanged.
- R5: `commitReq` during a load starts a cycle only if at least one byte was loaded and `bitsPending` is low. Otherwise the load is discarded, no cycle starts, and the array is unchanged.
- R6: `abortReq` during a load discards it. A following `commitReq` then starts nothing.
- R7: `busy` rises on the clock edge that accepts a commit or erase and stays high for exactly CYCLE_TICKS cycles. `arrWe` is high only while busy, for exactly 128 cycles, and visits offsets 0 through 127 in ascending order.
- R8: `eraseReq` while idle sets all 128 bytes of the page of `startAddr` to 0xFF, using the same timed cycle as a write.
- R9: While `busy` is high, `loadStart`, `byteValid`, `commitReq` and `eraseReq` have no effect: no new load, no new cycle and no array change.
- R10: In one cycle during a load, `abortReq` wins over `commitReq`, and `commitReq` wins over `byteValid`, so a byte strobed together with an accepted commit is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startAddr | input | 16 | Start address for a load, or page address for an erase |
| loadStart | input | 1 | Begin a load at `startAddr` (idle only) |
| byteValid | input | 1 | Store `byteData` at the current offset |
| byteData | input | 8 | Data byte |
| bitsPending | input | 1 | High when an incomplete byte has been shifted in |
| commitReq | input | 1 | End of the command, request a commit |
| abortReq | input | 1 | Discard the current load |
| eraseReq | input | 1 | Erase the page of `startAddr` (idle only) |
| rdAddr | input | PAGE_SEL_BITS+7 | Array read index |
| rdData | output | 8 | Array contents at `rdAddr` |
| busy | output | 1 | Timed cycle in progress |
| arrWe | output | 1 | Array write strobe |
| arrAddr | output | 16 | Array write address |
| arrWdata | output | 8 | Array write data |

## Verification
The main function is tried with a full 128-byte load from offset 0, a short load that crosses offset 127, and a 130-byte load whose last two bytes land on the first two. Together these separate correct wrapping from carrying into the next page and from a drop of extra bytes. Full-page readback after each short load shows that untouched bytes are rewritten with their old values rather than erased. Commits with a pending partial byte, with no bytes, after an abort and in the same cycle as an abort or a data byte show which requests are honoured. Requests injected in the middle of a cycle, plus aliased page addresses, cover the ignore and indexing rules.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int OFF_W      = 7;
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int PG_W       = ADDR_W - OFF_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CYCLE
  } pwbState_t;

  typedef struct packed {
    logic             capture;
    logic             storeByte;
    logic             eraseMode;
    logic             wrEn;
    logic [OFF_W-1:0] wrIdx;
  } pwbStrobes_t;
endpackage

// File: rtl/pwb_array.sv
module pwb_array
  import pwb_pkg::*;
#(
  parameter int PAGE_SEL_BITS = 4
) (
  input  logic                             clk,
  input  logic                             wrEn,
  input  logic [PAGE_SEL_BITS+OFF_W-1:0]   wrIdx,
  input  logic [DATA_W-1:0]                wrData,
  input  logic [PAGE_SEL_BITS+OFF_W-1:0]   rdIdxA,
  output logic [DATA_W-1:0]                rdDataA,
  input  logic [PAGE_SEL_BITS+OFF_W-1:0]   rdIdxB,
  output logic [DATA_W-1:0]                rdDataB
);
  localparam int IDX_W = PAGE_SEL_BITS + OFF_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) cells[wrIdx] <= wrData;
  end

  assign rdDataA = cells[rdIdxA];
  assign rdDataB = cells[rdIdxB];
endmodule

// File: rtl/pwb_control.sv
module pwb_control
  import pwb_pkg::*;
#(
  parameter int CYCLE_TICKS = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadStart,
  input  logic        byteValid,
  input  logic        bitsPending,
  input  logic        commitReq,
  input  logic        abortReq,
  input  logic        eraseReq,
  output pwbStrobes_t strobes,
  output logic        busy
);
  localparam int CNT_W = $clog2(CYCLE_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_TICK  = CNT_W'(CYCLE_TICKS - 1);
  localparam logic [CNT_W-1:0] PAGE_TICKS = CNT_W'(PAGE_BYTES);

  generate
    if (CYCLE_TICKS < PAGE_BYTES) begin : g_bad_cycle
      $error("CYCLE_TICKS must cover one tick per page byte");
    end
  endgenerate

  pwbState_t        st, stNext;
  logic [CNT_W-1:0] tickCnt;
  logic             anyByte;
  logic             eraseLatched;
  logic             capture, store, goErase;

  always_comb begin
    stNext  = st;
    capture = 1'b0;
    store   = 1'b0;
    goErase = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (loadStart) begin
          capture = 1'b1;
          stNext  = ST_LOAD;
        end else if (eraseReq) begin
          capture = 1'b1;
          goErase = 1'b1;
          stNext  = ST_CYCLE;
        end
      end
      ST_LOAD: begin
        if (abortReq) begin
          stNext = ST_IDLE;
        end else if (commitReq) begin
          stNext = (anyByte && !bitsPending) ? ST_CYCLE : ST_IDLE;
        end else if (byteValid) begin
          store = 1'b1;
        end
      end
      ST_CYCLE: begin
        if (tickCnt == LAST_TICK) stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st           <= ST_IDLE;
      tickCnt      <= '0;
      anyByte      <= 1'b0;
      eraseLatched <= 1'b0;
    end else begin
      st <= stNext;
      if (st != ST_CYCLE) tickCnt <= '0;
      else                tickCnt <= tickCnt + CNT_W'(1);
      if (capture)    anyByte <= 1'b0;
      else if (store) anyByte <= 1'b1;
      if (capture) eraseLatched <= goErase;
    end
  end

  assign busy              = (st == ST_CYCLE);
  assign strobes.capture   = capture;
  assign strobes.storeByte = store;
  assign strobes.eraseMode = eraseLatched;
  assign strobes.wrEn      = busy && (tickCnt < PAGE_TICKS);
  assign strobes.wrIdx     = tickCnt[OFF_W-1:0];

  // R7 / R5: a cycle only begins in answer to a commit or erase request
  assert_start_on_req_R7 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(commitReq || eraseReq));

  // R9: no byte is stored while a cycle runs
  assert_no_store_busy_R9 : assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobes.storeByte && !strobes.capture);
endmodule

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import pwb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pwbStrobes_t       strobes,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] byteData,
  input  logic [DATA_W-1:0] arrRdata,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrWdata
);
  logic [PG_W-1:0]       pageBase;
  logic [OFF_W-1:0]      loadOff;
  logic [PAGE_BYTES-1:0] loadedMask;
  logic [DATA_W-1:0]     pageLatch [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageBase   <= '0;
      loadOff    <= '0;
      loadedMask <= '0;
    end else if (strobes.capture) begin
      pageBase   <= startAddr[ADDR_W-1:OFF_W];
      loadOff    <= startAddr[OFF_W-1:0];
      loadedMask <= '0;
    end else if (strobes.storeByte) begin
      loadedMask[loadOff] <= 1'b1;
      loadOff             <= loadOff + OFF_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.storeByte) pageLatch[loadOff] <= byteData;
  end

  always_comb begin
    if (strobes.eraseMode)               arrWdata = {DATA_W{1'b1}};
    else if (loadedMask[strobes.wrIdx])  arrWdata = pageLatch[strobes.wrIdx];
    else                                 arrWdata = arrRdata;
  end

  assign arrWe   = strobes.wrEn;
  assign arrAddr = {pageBase, strobes.wrIdx};

  // R3: a stored byte moves the load offset forward by exactly one
  assert_offset_step_R3 : assert property (@(posedge clk) disable iff (!rstN)
    strobes.storeByte |=> loadOff == $past(loadOff) + OFF_W'(1));
endmodule

// File: rtl/page_program_buffer.sv
module page_program_buffer
  import pwb_pkg::*;
#(
  parameter int CYCLE_TICKS   = 200,
  parameter int PAGE_SEL_BITS = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [15:0]                      startAddr,
  input  logic                             loadStart,
  input  logic                             byteValid,
  input  logic [7:0]                       byteData,
  input  logic                             bitsPending,
  input  logic                             commitReq,
  input  logic                             abortReq,
  input  logic                             eraseReq,
  input  logic [PAGE_SEL_BITS+6:0]         rdAddr,
  output logic [7:0]                       rdData,
  output logic                             busy,
  output logic                             arrWe,
  output logic [15:0]                      arrAddr,
  output logic [7:0]                       arrWdata
);
  localparam int IDX_W = PAGE_SEL_BITS + OFF_W;

  pwbStrobes_t       strobes;
  logic [DATA_W-1:0] mergeRd;

  pwb_control #(.CYCLE_TICKS(CYCLE_TICKS)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .loadStart(loadStart), .byteValid(byteValid), .bitsPending(bitsPending),
    .commitReq(commitReq), .abortReq(abortReq), .eraseReq(eraseReq),
    .strobes(strobes), .busy(busy)
  );

  pwb_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .startAddr(startAddr), .byteData(byteData), .arrRdata(mergeRd),
    .arrWe(arrWe), .arrAddr(arrAddr), .arrWdata(arrWdata)
  );

  pwb_array #(.PAGE_SEL_BITS(PAGE_SEL_BITS)) arr_i (
    .clk(clk),
    .wrEn(arrWe), .wrIdx(arrAddr[IDX_W-1:0]), .wrData(arrWdata),
    .rdIdxA(arrAddr[IDX_W-1:0]), .rdDataA(mergeRd),
    .rdIdxB(rdAddr), .rdDataB(rdData)
  );

  int unsigned busyRun;
  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  // R7: busy lasts exactly CYCLE_TICKS cycles
  assert_busy_length_R7 : assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyRun == CYCLE_TICKS);

  // R7: array writes happen only inside a cycle
  assert_we_in_cycle_R7 : assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> busy);

  // R2: the page under write does not change within a cycle
  assert_page_fixed_R2 : assert property (@(posedge clk) disable iff (!rstN)
    arrWe && $past(arrWe) |-> arrAddr[15:7] == $past(arrAddr[15:7]));

  // R7: offsets are visited in ascending order
  assert_offset_order_R7 : assert property (@(posedge clk) disable iff (!rstN)
    arrWe && $past(arrWe) |-> arrAddr[6:0] == $past(arrAddr[6:0]) + 7'd1);
endmodule

// File: tb/page_program_buffer_tb_top.sv
`timescale 1ns/1ps
module page_program_buffer_tb_top;
  localparam int CYC   = 200;
  localparam int PSB   = 4;
  localparam int IDXW  = PSB + 7;
  localparam int MEMN  = 1 << IDXW;

  logic clk = 1'b0;
  logic rstN;
  logic [15:0] startAddr;
  logic loadStart, byteValid, bitsPending, commitReq, abortReq, eraseReq;
  logic [7:0] byteData;
  logic [IDXW-1:0] rdAddr;
  logic [7:0] rdData, arrWdata;
  logic busy, arrWe;
  logic [15:0] arrAddr;

  always #5 clk = ~clk;

  page_program_buffer #(.CYCLE_TICKS(CYC), .PAGE_SEL_BITS(PSB)) dut_i (
    .clk(clk), .rstN(rstN), .startAddr(startAddr), .loadStart(loadStart),
    .byteValid(byteValid), .byteData(byteData), .bitsPending(bitsPending),
    .commitReq(commitReq), .abortReq(abortReq), .eraseReq(eraseReq),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .arrWe(arrWe),
    .arrAddr(arrAddr), .arrWdata(arrWdata)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  logic [7:0]  model [MEMN];
  logic [7:0]  shLat [128];
  bit          shMsk [128];
  logic [6:0]  shOff;
  logic [15:0] shBase;
  logic [8:0]  curPage;

  typedef struct {
    logic [IDXW-1:0] idx;
    logic [7:0]      exp;
    string           tag;
  } rdItem_t;
  rdItem_t sbq[$];
  int inFlight = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor: read the array and compare with the queued model value
  initial begin
    rdAddr = '0;
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        rdItem_t it;
        it = sbq.pop_front();
        rdAddr = it.idx;
        #1;
        check(rdData == it.exp, it.tag, "array byte", int'(rdData), int'(it.exp));
        inFlight--;
      end
    end
  end

  task automatic expectPage(int page, string tag);
    for (int i = 0; i < 128; i++) begin
      rdItem_t it;
      it.idx = IDXW'(page * 128 + i);
      it.exp = model[page * 128 + i];
      it.tag = tag;
      sbq.push_back(it);
      inFlight++;
    end
    while (inFlight > 0) @(negedge clk);
  endtask

  function automatic int modelIdx(logic [15:0] base, int off);
    return int'(base[IDXW-1:7]) * 128 + off;
  endfunction

  task automatic beginLoad(logic [15:0] a);
    loadStart = 1'b1; startAddr = a;
    @(negedge clk);
    loadStart = 1'b0;
    shBase = a; shOff = a[6:0];
    for (int i = 0; i < 128; i++) shMsk[i] = 1'b0;
  endtask

  task automatic sendByte(logic [7:0] d);
    byteValid = 1'b1; byteData = d;
    @(negedge clk);
    byteValid = 1'b0;
    shLat[shOff] = d; shMsk[shOff] = 1'b1; shOff = shOff + 7'd1;
  endtask

  task automatic applyShadow();
    for (int i = 0; i < 128; i++)
      if (shMsk[i]) model[modelIdx(shBase, i)] = shLat[i];
    curPage = shBase[15:7];
  endtask

  task automatic observeCycle(bit expectGo, string tag, bit inject);
    int n = 0;
    int weN = 0;
    int lastOff = -1;
    bit orderOk = 1;
    bit pageOk = 1;
    if (!expectGo) begin
      for (int k = 0; k < 3; k++) begin
        check(busy == 1'b0, tag, "no cycle started", int'(busy), 0);
        @(negedge clk);
      end
      return;
    end
    check(busy == 1'b1, tag, "busy after accept", int'(busy), 1);
    while (busy && n < CYC + 10) begin
      if (arrWe) begin
        if (int'(arrAddr[6:0]) != lastOff + 1) orderOk = 0;
        lastOff = int'(arrAddr[6:0]);
        if (arrAddr[15:7] != curPage) pageOk = 0;
        weN++;
      end
      if (inject && n == 20) begin
        loadStart = 1'b1; eraseReq = 1'b1; commitReq = 1'b1;
        byteValid = 1'b1; byteData = 8'h33; startAddr = 16'h0100;
      end else if (inject && n == 21) begin
        loadStart = 1'b0; eraseReq = 1'b0; commitReq = 1'b0; byteValid = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    check(n == CYC, "R7", "busy length", n, CYC);
    check(weN == 128, "R7", "write strobes", weN, 128);
    check(orderOk, "R7", "ascending offsets", int'(orderOk), 1);
    check(pageOk, "R2", "page held in cycle", int'(pageOk), 1);
    check(busy == 1'b0, inject ? "R9" : "R7", "idle after cycle", int'(busy), 0);
  endtask

  task automatic doCommit(bit pend, bit expectGo, string tag);
    commitReq = 1'b1; bitsPending = pend;
    @(negedge clk);
    commitReq = 1'b0; bitsPending = 1'b0;
    if (expectGo) applyShadow();
    observeCycle(expectGo, tag, 1'b0);
  endtask

  task automatic doErase(logic [15:0] a, string tag);
    eraseReq = 1'b1; startAddr = a;
    @(negedge clk);
    eraseReq = 1'b0;
    for (int i = 0; i < 128; i++) model[int'(a[IDXW-1:7]) * 128 + i] = 8'hFF;
    curPage = a[15:7];
    observeCycle(1'b1, tag, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; startAddr = '0; loadStart = 0; byteValid = 0; byteData = '0;
    bitsPending = 0; commitReq = 0; abortReq = 0; eraseReq = 0;
    curPage = '0; shOff = '0; shBase = '0;
    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    check(arrWe == 1'b0, "R1", "arrWe in reset", int'(arrWe), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);

    // R8: erase every page to a known state
    for (int p = 0; p < (1 << PSB); p++) doErase(16'(p * 128 + 5), "R8");
    expectPage(0, "R8");
    expectPage(15, "R8");

    // R4: full page from offset 0
    beginLoad(16'h0100);
    for (int i = 0; i < 128; i++) sendByte(8'(i) ^ 8'h5A);
    doCommit(1'b0, 1'b1, "R4");
    expectPage(2, "R4");

    // R3 + R4: short load crossing offset 127 merges with old page
    beginLoad(16'h0180);
    for (int i = 0; i < 128; i++) sendByte(8'(i + 3));
    doCommit(1'b0, 1'b1, "R4");
    beginLoad(16'h01FE);
    for (int i = 0; i < 5; i++) sendByte(8'hA0 + 8'(i));
    doCommit(1'b0, 1'b1, "R3");
    expectPage(3, "R3");

    // R3: 130 bytes from offset 0x10, last two overwrite the first two
    beginLoad(16'h0210);
    for (int i = 0; i < 130; i++) sendByte(8'(i * 7));
    doCommit(1'b0, 1'b1, "R3");
    expectPage(4, "R3");

    // R5: pending partial byte discards the load
    beginLoad(16'h0300);
    for (int i = 0; i < 3; i++) sendByte(8'h11);
    doCommit(1'b1, 1'b0, "R5");
    expectPage(6, "R5");
    // R5: no bytes loaded
    beginLoad(16'h0300);
    doCommit(1'b0, 1'b0, "R5");

    // R6: abort then commit
    beginLoad(16'h0300);
    for (int i = 0; i < 4; i++) sendByte(8'h22);
    abortReq = 1'b1; @(negedge clk); abortReq = 1'b0;
    doCommit(1'b0, 1'b0, "R6");
    expectPage(6, "R6");

    // R10: abort beats commit in the same cycle
    beginLoad(16'h0300);
    sendByte(8'h44); sendByte(8'h45);
    abortReq = 1'b1; commitReq = 1'b1; @(negedge clk);
    abortReq = 1'b0; commitReq = 1'b0;
    observeCycle(1'b0, "R10", 1'b0);
    expectPage(6, "R10");
    // R10: byte strobed with an accepted commit is not stored
    beginLoad(16'h0305);
    sendByte(8'h66);
    commitReq = 1'b1; byteValid = 1'b1; byteData = 8'hEE; @(negedge clk);
    commitReq = 1'b0; byteValid = 1'b0;
    applyShadow();
    observeCycle(1'b1, "R10", 1'b0);
    expectPage(6, "R10");

    // R9: requests injected while busy are ignored
    beginLoad(16'h0380);
    for (int i = 0; i < 3; i++) sendByte(8'hC0 + 8'(i));
    commitReq = 1'b1; @(negedge clk); commitReq = 1'b0;
    applyShadow();
    observeCycle(1'b1, "R9", 1'b1);
    expectPage(7, "R9");
    expectPage(2, "R9");
    doCommit(1'b0, 1'b0, "R9");

    // R2: page 0x12 aliases page 2 in a 16-page array
    beginLoad(16'h0900);
    sendByte(8'h77);
    doCommit(1'b0, 1'b1, "R2");
    expectPage(2, "R2");

    // R8: erase of a written page; R4: neighbour untouched
    doErase(16'h0210, "R8");
    expectPage(4, "R8");
    expectPage(3, "R4");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule